// File: doc/BRIEF.md
# Banked Program Counter Unit

This block holds the program counter of a small processor together with a two-stage code bank selector, and turns them into a 23-bit instruction fetch address. The counter is 16 bits wide. Its lower half of the space (bit 15 clear) always maps to the fixed region at the bottom of the fetch space. Its upper half (bit 15 set) is a window whose position is chosen by an 8-bit active bank value.

Software never writes the active bank directly. It writes a pending bank register, and the pending value moves into the active bank only on the clock edge that takes a branch. A far jump is therefore a pending-bank write followed by an ordinary branch. Code keeps running from the old bank until the jump itself, and the jump lands in the new one. The advance strobe steps the counter by one. The branch strobe loads a target. Both are plain single-cycle control pins. The fetch address is a continuous combinational output of the registered state, so it has no handshake.

Top module: `bankpc_unit`

## Requirements
- R1: While reset (rst_n low) is applied, the counter, the pending bank and the active bank are all zero, and so is the fetch address.
- R2: A cycle with adv_i high and br_i low adds one to the counter at the next edge. The counter wraps from 0xFFFF to 0x0000.
- R3: Cycles without br_i never change the active bank, however many times the counter advances or wraps.
- R4: A cycle with ubank_we_i high loads ubank_wdata_i into the pending bank at the next edge and leaves the active bank unchanged, unless br_i is also high (see R6).
- R5: A cycle with br_i high loads br_target_i into the counter. On the same edge it copies the pending bank into the active bank, so the fetch address in the next cycle reflects both new values.
- R6: If ubank_we_i and br_i are high in the same cycle, the active bank receives the pending bank's old value and the pending bank takes the new write data.
- R7: Fetch address bits 14..0 equal counter bits 14..0. When counter bit 15 is 1, fetch bits 22..15 equal the active bank. When counter bit 15 is 0, fetch bits 22..15 are zero.
- R8: If br_i and adv_i are high in the same cycle, the branch wins: the counter takes br_target_i and is not incremented.
- R9: A cycle with adv_i, br_i and ubank_we_i all low leaves the counter, the pending bank and the active bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance strobe: counter plus one |
| br_i | input | 1 | Branch strobe: load target, promote pending bank |
| br_target_i | input | 16 | Branch target for the counter |
| ubank_we_i | input | 1 | Pending bank write enable |
| ubank_wdata_i | input | 8 | Pending bank write data |
| pc_o | output | 16 | Current counter value |
| ubank_o | output | 8 | Pending bank value |
| vbank_o | output | 8 | Active bank value |
| fetch_addr_o | output | 23 | Instruction fetch address |

## Verification
Every one of the 256 pending-bank values is written and then promoted by a branch into the banked window. This shows that promotion copies the exact pending value and that a write alone never reaches the active bank. Branch targets are swept across the whole 16-bit range, including both sides of the bit-15 boundary, so that the fixed and banked address mappings are told apart. The counter is run across the 0x7FFF/0x8000 and 0xFFFF/0x0000 edges with a nonzero active bank, which separates incrementing from bank changes. Same-cycle combinations of write with branch and of branch with advance pin down the ordering rules.

// File: rtl/bankpc_pkg.sv
package bankpc_pkg;

  // Counter update selection, ordered by priority (load beats step).
  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_LOAD = 2'd2
  } pc_sel_e;

  function automatic pc_sel_e pc_select(input logic br, input logic adv);
    if (br)       return PC_LOAD;
    else if (adv) return PC_STEP;
    else          return PC_HOLD;
  endfunction

endpackage

// File: rtl/bankpc_pc_reg.sv
module bankpc_pc_reg
  import bankpc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            br_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);

  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  pc_sel_e         sel;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    sel = pc_select(br_i, adv_i);
    unique case (sel)
      PC_LOAD: pc_d = target_i;
      PC_STEP: pc_d = pc_q + PC_ONE;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/bankpc_bank_pair.sv
module bankpc_bank_pair #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic              promote_i,
  output logic [BANK_W-1:0] pend_o,
  output logic [BANK_W-1:0] act_o
);

  logic [BANK_W-1:0] pend_q;
  logic [BANK_W-1:0] act_q;

  // Pending stage: written by software.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_q <= '0;
    else if (we_i) pend_q <= wdata_i;
  end

  // Active stage: samples the pending value held before this edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         act_q <= '0;
    else if (promote_i) act_q <= pend_q;
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

endmodule

// File: rtl/bankpc_fetch_map.sv
module bankpc_fetch_map #(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  localparam int OFS_W = PC_W - 1,
  localparam int ADR_W = BANK_W + OFS_W
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [ADR_W-1:0]  addr_o
);

  logic window_sel;
  assign window_sel = pc_i[PC_W-1];

  // The offset passes straight through.
  assign addr_o[OFS_W-1:0] = pc_i[OFS_W-1:0];

  // Each upper bit is gated by the window select.
  for (genvar b = 0; b < BANK_W; b++) begin : g_bank_bit
    assign addr_o[OFS_W+b] = bank_i[b] & window_sel;
  end

endmodule

// File: rtl/bankpc_unit.sv
module bankpc_unit #(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  localparam int ADR_W = BANK_W + PC_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              br_i,
  input  logic [PC_W-1:0]   br_target_i,
  input  logic              ubank_we_i,
  input  logic [BANK_W-1:0] ubank_wdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [BANK_W-1:0] ubank_o,
  output logic [BANK_W-1:0] vbank_o,
  output logic [ADR_W-1:0]  fetch_addr_o
);

  logic [PC_W-1:0]   pc_w;
  logic [BANK_W-1:0] act_w;

  bankpc_pc_reg #(.PC_W(PC_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv_i),
    .br_i     (br_i),
    .target_i (br_target_i),
    .pc_o     (pc_w)
  );

  bankpc_bank_pair #(.BANK_W(BANK_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (ubank_we_i),
    .wdata_i   (ubank_wdata_i),
    .promote_i (br_i),
    .pend_o    (ubank_o),
    .act_o     (act_w)
  );

  bankpc_fetch_map #(.PC_W(PC_W), .BANK_W(BANK_W)) u_map (
    .pc_i   (pc_w),
    .bank_i (act_w),
    .addr_o (fetch_addr_o)
  );

  assign pc_o    = pc_w;
  assign vbank_o = act_w;

endmodule

// File: rtl/bankpc_unit_chk.sv
module bankpc_unit_chk #(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  localparam int ADR_W = BANK_W + PC_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_i,
  input logic              br_i,
  input logic [PC_W-1:0]   br_target_i,
  input logic              ubank_we_i,
  input logic [BANK_W-1:0] ubank_wdata_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [BANK_W-1:0] ubank_o,
  input logic [BANK_W-1:0] vbank_o,
  input logic [ADR_W-1:0]  fetch_addr_o
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pc_o == '0 && ubank_o == '0 && vbank_o == '0));

  assert_step_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !br_i) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !br_i |=> $stable(vbank_o));

  assert_pend_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ubank_we_i |=> ubank_o == $past(ubank_wdata_i));

  assert_branch_promote_R5: assert property (@(posedge clk) disable iff (!rst_n)
    br_i |=> (pc_o == $past(br_target_i) && vbank_o == $past(ubank_o)));

  assert_low_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_o[PC_W-1] |-> fetch_addr_o[ADR_W-1:PC_W-1] == '0);

  assert_high_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[PC_W-1] |-> fetch_addr_o[ADR_W-1:PC_W-1] == vbank_o);

  assert_offset_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr_o[PC_W-2:0] == pc_o[PC_W-2:0]);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !br_i && !ubank_we_i) |=> ($stable(pc_o) && $stable(ubank_o)));

endmodule

bind bankpc_unit bankpc_unit_chk #(.PC_W(PC_W), .BANK_W(BANK_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .adv_i         (adv_i),
  .br_i          (br_i),
  .br_target_i   (br_target_i),
  .ubank_we_i    (ubank_we_i),
  .ubank_wdata_i (ubank_wdata_i),
  .pc_o          (pc_o),
  .ubank_o       (ubank_o),
  .vbank_o       (vbank_o),
  .fetch_addr_o  (fetch_addr_o)
);

// File: tb/test_bankpc_unit.sv
module test_bankpc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_i = 1'b0;
  logic        br_i = 1'b0;
  logic [15:0] br_target_i = '0;
  logic        ubank_we_i = 1'b0;
  logic [7:0]  ubank_wdata_i = '0;
  logic [15:0] pc_o;
  logic [7:0]  ubank_o;
  logic [7:0]  vbank_o;
  logic [22:0] fetch_addr_o;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_pc = '0;
  logic [7:0]  m_u  = '0;
  logic [7:0]  m_v  = '0;

  always #2 clk = ~clk;

  bankpc_unit i_bankpc_unit (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .br_i(br_i),
    .br_target_i(br_target_i), .ubank_we_i(ubank_we_i),
    .ubank_wdata_i(ubank_wdata_i), .pc_o(pc_o), .ubank_o(ubank_o),
    .vbank_o(vbank_o), .fetch_addr_o(fetch_addr_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [22:0] exp_fetch(input logic [15:0] pc, input logic [7:0] v);
    logic [22:0] a;
    a = {8'h00, pc[14:0]};
    if (pc[15]) a[22:15] = v;
    return a;
  endfunction

  task automatic check_all(input string tag);
    chk(tag, "pc", 32'(pc_o), 32'(m_pc));
    chk(tag, "ubank", 32'(ubank_o), 32'(m_u));
    chk(tag, "vbank", 32'(vbank_o), 32'(m_v));
    chk("R7", "fetch", 32'(fetch_addr_o), 32'(exp_fetch(m_pc, m_v)));
  endtask

  // One clock: drive, take the edge, update the model, sample 1 ns later.
  task automatic cyc(input string tag, input logic adv, input logic br,
                     input logic [15:0] tgt, input logic we, input logic [7:0] wd);
    adv_i = adv; br_i = br; br_target_i = tgt; ubank_we_i = we; ubank_wdata_i = wd;
    @(posedge clk);
    #1;
    if (br) begin
      m_v  = m_u;
      m_pc = tgt;
    end else if (adv) begin
      m_pc = m_pc + 16'd1;
    end
    if (we) m_u = wd;
    adv_i = 1'b0; br_i = 1'b0; ubank_we_i = 1'b0;
    check_all(tag);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R1: reset state, even with strobes active
    adv_i = 1'b1; br_i = 1'b1; br_target_i = 16'hABCD;
    ubank_we_i = 1'b1; ubank_wdata_i = 8'h5A;
    repeat (3) begin
      @(posedge clk); #1;
      check_all("R1");
    end
    adv_i = 1'b0; br_i = 1'b0; ubank_we_i = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1");

    // R2: sequential advance from zero
    for (int i = 0; i < 8; i++) cyc("R2", 1'b1, 1'b0, 16'h0, 1'b0, 8'h0);
    // R9: idle cycles hold everything
    for (int i = 0; i < 4; i++) cyc("R9", 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);

    // R4: every pending value; a write alone never moves the active bank
    for (int u = 0; u < 256; u++) cyc("R4", 1'b0, 1'b0, 16'h0, 1'b1, 8'(u));

    // R5: promote every value into the banked window
    for (int u = 0; u < 256; u++) begin
      cyc("R4", 1'b0, 1'b0, 16'h0, 1'b1, 8'(u));
      cyc("R5", 1'b0, 1'b1, 16'h8000 | 16'(u * 37), 1'b0, 8'h0);
      cyc("R2", 1'b1, 1'b0, 16'h0, 1'b0, 8'h0);
    end

    // R7: targets across the whole counter range, both windows
    cyc("R4", 1'b0, 1'b0, 16'h0, 1'b1, 8'hC3);
    for (int t = 0; t < 65536; t += 97) begin
      cyc("R7", 1'b0, 1'b1, 16'(t), 1'b0, 8'h0);
      cyc("R7", 1'b0, 1'b1, 16'(t) ^ 16'h8000, 1'b0, 8'h0);
    end
    cyc("R7", 1'b0, 1'b1, 16'h7FFF, 1'b0, 8'h0);
    cyc("R7", 1'b0, 1'b1, 16'hFFFF, 1'b0, 8'h0);

    // R2/R3: cross 0x7FFF->0x8000 and 0xFFFF->0x0000 with a set bank
    cyc("R4", 1'b0, 1'b0, 16'h0, 1'b1, 8'h3C);
    cyc("R5", 1'b0, 1'b1, 16'h7FFD, 1'b0, 8'h0);
    cyc("R4", 1'b0, 1'b0, 16'h0, 1'b1, 8'h99);
    for (int i = 0; i < 6; i++) cyc("R3", 1'b1, 1'b0, 16'h0, 1'b0, 8'h0);
    cyc("R5", 1'b0, 1'b1, 16'hFFFC, 1'b0, 8'h0);
    cyc("R4", 1'b0, 1'b0, 16'h0, 1'b1, 8'h11);
    for (int i = 0; i < 6; i++) cyc("R2", 1'b1, 1'b0, 16'h0, 1'b0, 8'h0);
    for (int i = 0; i < 300; i++) cyc("R3", 1'b1, 1'b0, 16'h0, (i % 7) == 0, 8'(i));

    // R6: write and branch together
    cyc("R4", 1'b0, 1'b0, 16'h0, 1'b1, 8'hA1);
    cyc("R6", 1'b0, 1'b1, 16'h9000, 1'b1, 8'hB2);
    cyc("R6", 1'b0, 1'b1, 16'h9100, 1'b1, 8'hC3);
    cyc("R6", 1'b1, 1'b1, 16'h8123, 1'b1, 8'hD4);

    // R8: branch and advance together
    for (int t = 0; t < 16; t++) cyc("R8", 1'b1, 1'b1, 16'(t * 4099), 1'b0, 8'h0);

    // R1: reset again mid-run
    rst_n = 1'b0;
    #1;
    m_pc = '0; m_u = '0; m_v = '0;
    check_all("R1");
    @(posedge clk); #1;
    rst_n = 1'b1;
    cyc("R9", 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule